// File: doc/BRIEF.md
# Data Access Misalignment and Abort Capture Unit

This unit sits beside a shared internal bus that serves up to four masters. It checks every data access against its size and aborts any access whose address is not a multiple of that size. It also aborts any access, data or instruction fetch, that the address decoder marks as undefined through an external request. The abort goes back to the requesting master in the same cycle as the access.

On the first abort it stores a status record: the master that made the access, the abort cause, the access size, the direction, the data-or-fetch flag and the full address. Software reads the record from plain register outputs. The record stays unchanged until software clears it. A further abort that arrives while a record is held leaves the record as it is and sets a sticky overrun flag.

Top module: `access_abort_monitor`

## Requirements
- R1: A valid data access of halfword size (size code 1) whose address bit 0 is 1 raises abort_o in the same cycle.
- R2: A valid data access of word size (size code 2) whose address bits 1:0 are not 00 raises abort_o in the same cycle. Size code 3 is checked exactly as a word.
- R3: A byte access (size code 0) is never misaligned. An instruction fetch (req_data_i = 0) is never checked for alignment. Without an external abort, neither raises abort_o.
- R4: abort_o is raised whenever req_valid_i and ext_abort_i are both 1, for any size or kind of access. abort_o is never raised while req_valid_i is 0, and such a cycle captures nothing.
- R5: On the first abort while no record is held, the record is captured on that clock edge. In the next cycle stat_valid_o is 1, and stat_master_o, stat_size_o, stat_write_o, stat_data_o and stat_addr_o equal the inputs of the aborting access.
- R6: stat_type_o is 0 for a misalignment abort and 1 for an undefined-address abort. When both causes occur in one access, it is 0.
- R7: While stat_valid_o is 1 and clear_i is 0, the record fields do not change. Any further abort sets stat_overrun_o to 1, and it stays 1 until cleared.
- R8: clear_i sets stat_valid_o and stat_overrun_o to 0 on the next edge. An abort in the same cycle as clear_i is captured as a fresh record, with stat_valid_o 1 and stat_overrun_o 0.
- R9: An asynchronous reset (rst_ni low) sets every status output to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | An access is presented this cycle |
| req_master_i | input | 2 | Index of the requesting master |
| req_addr_i | input | 32 | Byte address of the access |
| req_size_i | input | 2 | Size code: 0 byte, 1 halfword, 2 word, 3 treated as word |
| req_write_i | input | 1 | 1 for a write, 0 for a read |
| req_data_i | input | 1 | 1 for a data access, 0 for an instruction fetch |
| ext_abort_i | input | 1 | Address decoder reports an undefined address |
| clear_i | input | 1 | Software clears the valid and overrun flags |
| abort_o | output | 1 | Abort to the current master, combinational |
| stat_valid_o | output | 1 | A record is held |
| stat_overrun_o | output | 1 | Sticky flag: an abort arrived while a record was held |
| stat_master_o | output | 2 | Captured master index |
| stat_type_o | output | 1 | Captured cause: 0 misalignment, 1 undefined address |
| stat_size_o | output | 2 | Captured size code |
| stat_write_o | output | 1 | Captured direction |
| stat_data_o | output | 1 | Captured data-or-fetch flag |
| stat_addr_o | output | 32 | Captured address |

## Verification
abort_o is a combinational function of the current inputs. The bench drives each access just after a falling edge and samples abort_o 1 ns later, before the next rising edge. Every status output passes through one register. The bench reads it at the next falling edge, one full cycle after the access, and reads clear and reset effects in the same way. A sweep covers every combination of master, size code, the two low address bits, direction, access kind and external abort. Each point starts from an empty record, so every point exercises both the same-cycle abort and the one-cycle capture.

// File: rtl/abort_mon_pkg.sv
package abort_mon_pkg;
  localparam int unsigned SZ_W     = 2;
  localparam int unsigned MAX_LG   = 2;  // widest checked access: 2^2 bytes

  localparam logic [SZ_W-1:0] SZ_BYTE = 2'd0;
  localparam logic [SZ_W-1:0] SZ_HALF = 2'd1;
  localparam logic [SZ_W-1:0] SZ_WORD = 2'd2;

  localparam logic CAUSE_MISALIGN = 1'b0;
  localparam logic CAUSE_UNDEF    = 1'b1;
endpackage

// File: rtl/amon_align_check.sv
module amon_align_check
  import abort_mon_pkg::*;
#(
  parameter int unsigned LG = MAX_LG
) (
  input  logic [LG-1:0]   addr_lo_i,
  input  logic [SZ_W-1:0] size_i,
  input  logic            is_data_i,
  output logic            misalign_o
);
  localparam logic [SZ_W-1:0] LG_CAP = SZ_W'(LG);

  logic [SZ_W-1:0] size_lg;
  logic [LG-1:0]   bit_bad;

  assign size_lg = (size_i > LG_CAP) ? LG_CAP : size_i;

  // bit b must be zero when the access spans more than 2^b bytes
  for (genvar b = 0; b < LG; b++) begin : g_bit
    localparam logic [SZ_W-1:0] IDX = SZ_W'(b);
    assign bit_bad[b] = addr_lo_i[b] & (size_lg > IDX);
  end

  assign misalign_o = is_data_i & (|bit_bad);
endmodule

// File: rtl/amon_cause_sel.sv
module amon_cause_sel
  import abort_mon_pkg::*;
(
  input  logic valid_i,
  input  logic misalign_i,
  input  logic undef_i,
  output logic abort_o,
  output logic cause_o
);
  logic hit_mis, hit_und;

  assign hit_mis = valid_i & misalign_i;
  assign hit_und = valid_i & undef_i;
  assign abort_o = hit_mis | hit_und;
  assign cause_o = hit_mis ? CAUSE_MISALIGN : CAUSE_UNDEF;
endmodule

// File: rtl/amon_status_reg.sv
module amon_status_reg
  import abort_mon_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned ID_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              abort_i,
  input  logic              clear_i,
  input  logic [ID_W-1:0]   master_i,
  input  logic              cause_i,
  input  logic [SZ_W-1:0]   size_i,
  input  logic              write_i,
  input  logic              data_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              valid_o,
  output logic              overrun_o,
  output logic [ID_W-1:0]   master_o,
  output logic              cause_o,
  output logic [SZ_W-1:0]   size_o,
  output logic              write_o,
  output logic              data_o,
  output logic [ADDR_W-1:0] addr_o
);
  typedef struct packed {
    logic [ID_W-1:0]   master;
    logic              cause;
    logic [SZ_W-1:0]   size;
    logic              write;
    logic              data;
    logic [ADDR_W-1:0] addr;
  } rec_t;

  rec_t rec_q, rec_d;
  logic valid_q, ovr_q;
  logic slot_free;

  assign slot_free = ~valid_q | clear_i;

  always_comb begin
    rec_d.master = master_i;
    rec_d.cause  = cause_i;
    rec_d.size   = size_i;
    rec_d.write  = write_i;
    rec_d.data   = data_i;
    rec_d.addr   = addr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rec_q   <= '0;
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (clear_i) begin
        valid_q <= 1'b0;
        ovr_q   <= 1'b0;
      end
      if (abort_i) begin
        if (slot_free) begin
          rec_q   <= rec_d;
          valid_q <= 1'b1;
        end else begin
          ovr_q   <= 1'b1;
        end
      end
    end
  end

  assign valid_o   = valid_q;
  assign overrun_o = ovr_q;
  assign master_o  = rec_q.master;
  assign cause_o   = rec_q.cause;
  assign size_o    = rec_q.size;
  assign write_o   = rec_q.write;
  assign data_o    = rec_q.data;
  assign addr_o    = rec_q.addr;
endmodule

// File: rtl/access_abort_monitor.sv
module access_abort_monitor
  import abort_mon_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned N_MASTERS = 4,
  localparam int unsigned ID_W     = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ID_W-1:0]   req_master_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [SZ_W-1:0]   req_size_i,
  input  logic              req_write_i,
  input  logic              req_data_i,
  input  logic              ext_abort_i,
  input  logic              clear_i,
  output logic              abort_o,
  output logic              stat_valid_o,
  output logic              stat_overrun_o,
  output logic [ID_W-1:0]   stat_master_o,
  output logic              stat_type_o,
  output logic [SZ_W-1:0]   stat_size_o,
  output logic              stat_write_o,
  output logic              stat_data_o,
  output logic [ADDR_W-1:0] stat_addr_o
);
  logic misalign, abort, cause;

  amon_align_check #(.LG(MAX_LG)) u_align (
    .addr_lo_i  (req_addr_i[MAX_LG-1:0]),
    .size_i     (req_size_i),
    .is_data_i  (req_data_i),
    .misalign_o (misalign)
  );

  amon_cause_sel u_cause (
    .valid_i    (req_valid_i),
    .misalign_i (misalign),
    .undef_i    (ext_abort_i),
    .abort_o    (abort),
    .cause_o    (cause)
  );

  amon_status_reg #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .abort_i   (abort),
    .clear_i   (clear_i),
    .master_i  (req_master_i),
    .cause_i   (cause),
    .size_i    (req_size_i),
    .write_i   (req_write_i),
    .data_i    (req_data_i),
    .addr_i    (req_addr_i),
    .valid_o   (stat_valid_o),
    .overrun_o (stat_overrun_o),
    .master_o  (stat_master_o),
    .cause_o   (stat_type_o),
    .size_o    (stat_size_o),
    .write_o   (stat_write_o),
    .data_o    (stat_data_o),
    .addr_o    (stat_addr_o)
  );

  assign abort_o = abort;
endmodule

// File: rtl/amon_checker.sv
module amon_checker
  import abort_mon_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned ID_W   = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [ID_W-1:0]   req_master_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [SZ_W-1:0]   req_size_i,
  input logic              req_write_i,
  input logic              req_data_i,
  input logic              ext_abort_i,
  input logic              clear_i,
  input logic              abort_o,
  input logic              stat_valid_o,
  input logic              stat_overrun_o,
  input logic [ID_W-1:0]   stat_master_o,
  input logic              stat_type_o,
  input logic [SZ_W-1:0]   stat_size_o,
  input logic              stat_write_o,
  input logic              stat_data_o,
  input logic [ADDR_W-1:0] stat_addr_o
);
  logic half_bad, word_bad;
  assign half_bad = req_data_i && (req_size_i == SZ_HALF) && req_addr_i[0];
  assign word_bad = req_data_i && (req_size_i[1]) && (req_addr_i[1:0] != 2'b00);

  AST_HALF_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && half_bad |-> abort_o); // R1
  AST_WORD_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && word_bad |-> abort_o); // R2
  AST_BYTE_FETCH_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !ext_abort_i && (!req_data_i || req_size_i == SZ_BYTE) |-> !abort_o); // R3
  AST_EXT_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && ext_abort_i |-> abort_o); // R4
  AST_NO_VALID_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> !abort_o); // R4
  AST_FIRST_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o && !stat_valid_o |=> stat_valid_o && stat_addr_o == $past(req_addr_i)
      && stat_master_o == $past(req_master_i) && stat_size_o == $past(req_size_i)
      && stat_write_o == $past(req_write_i) && stat_data_o == $past(req_data_i)); // R5
  AST_TYPE_MISALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o && !stat_valid_o && (half_bad || word_bad) |=> stat_type_o == CAUSE_MISALIGN); // R6
  AST_TYPE_UNDEF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o && !stat_valid_o && !(half_bad || word_bad) |=> stat_type_o == CAUSE_UNDEF); // R6
  AST_HOLD_RECORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_valid_o && !clear_i |=> stat_valid_o && $stable(stat_addr_o) && $stable(stat_master_o)
      && $stable(stat_type_o) && $stable(stat_size_o)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_valid_o && abort_o && !clear_i |=> stat_overrun_o); // R7
  AST_CLEAR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i && !abort_o |=> !stat_valid_o && !stat_overrun_o); // R8
  AST_CLEAR_COLLIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i && abort_o |=> stat_valid_o && !stat_overrun_o); // R8
endmodule

bind access_abort_monitor amon_checker #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .req_master_i   (req_master_i),
  .req_addr_i     (req_addr_i),
  .req_size_i     (req_size_i),
  .req_write_i    (req_write_i),
  .req_data_i     (req_data_i),
  .ext_abort_i    (ext_abort_i),
  .clear_i        (clear_i),
  .abort_o        (abort_o),
  .stat_valid_o   (stat_valid_o),
  .stat_overrun_o (stat_overrun_o),
  .stat_master_o  (stat_master_o),
  .stat_type_o    (stat_type_o),
  .stat_size_o    (stat_size_o),
  .stat_write_o   (stat_write_o),
  .stat_data_o    (stat_data_o),
  .stat_addr_o    (stat_addr_o)
);

// File: tb/access_abort_monitor_tb.sv
module access_abort_monitor_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [1:0]  master = '0;
  logic [31:0] addr = '0;
  logic [1:0]  size = '0;
  logic        wr = 1'b0;
  logic        dat = 1'b0;
  logic        ext = 1'b0;
  logic        clr = 1'b0;
  logic        abort;
  logic        s_valid, s_ovr, s_type, s_wr, s_dat;
  logic [1:0]  s_master, s_size;
  logic [31:0] s_addr;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  access_abort_monitor u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_master_i(master),
    .req_addr_i(addr), .req_size_i(size), .req_write_i(wr), .req_data_i(dat),
    .ext_abort_i(ext), .clear_i(clr), .abort_o(abort), .stat_valid_o(s_valid),
    .stat_overrun_o(s_ovr), .stat_master_o(s_master), .stat_type_o(s_type),
    .stat_size_o(s_size), .stat_write_o(s_wr), .stat_data_o(s_dat), .stat_addr_o(s_addr)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  function automatic bit exp_mis(input logic [1:0] sz, input logic [31:0] a, input logic d);
    if (!d) return 1'b0;
    if (sz == 2'd0) return 1'b0;
    if (sz == 2'd1) return a[0];
    return a[1:0] != 2'b00;
  endfunction

  task automatic drive(input logic [1:0] m, input logic [31:0] a, input logic [1:0] sz,
                       input logic w, input logic d, input logic e);
    valid = 1'b1; master = m; addr = a; size = sz; wr = w; dat = d; ext = e;
  endtask

  task automatic idle();
    valid = 1'b0; ext = 1'b0;
  endtask

  task automatic chk_rec(input string req, input logic [1:0] m, input logic [31:0] a,
                         input logic [1:0] sz, input logic w, input logic d, input logic t);
    chk(req, "master", 32'(s_master), 32'(m));
    chk(req, "addr", s_addr, a);
    chk(req, "size", 32'(s_size), 32'(sz));
    chk(req, "write", 32'(s_wr), 32'(w));
    chk(req, "data", 32'(s_dat), 32'(d));
    chk("R6", "type", 32'(s_type), 32'(t));
  endtask

  task automatic chk_zero(input string req);
    chk(req, "valid", 32'(s_valid), 0);
    chk(req, "overrun", 32'(s_ovr), 0);
    chk(req, "master", 32'(s_master), 0);
    chk(req, "type", 32'(s_type), 0);
    chk(req, "size", 32'(s_size), 0);
    chk(req, "write", 32'(s_wr), 0);
    chk(req, "data", 32'(s_dat), 0);
    chk(req, "addr", s_addr, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] a;
    logic        ea, mis;
    string       rq;
    // reset state, R9
    #3; chk_zero("R9");
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    @(negedge clk); chk_zero("R9");

    // exhaustive sweep, empty record at each point
    for (int idx = 0; idx < 512; idx++) begin
      logic [1:0] m, sz;
      logic w, d, e;
      m  = idx[1:0];
      sz = idx[3:2];
      a  = {idx[31:0] * 32'h0001_0103} & 32'hFFFF_FFFC | {30'd0, idx[5:4]};
      a  = {a[31:2], idx[5:4]};
      w  = idx[6]; d = idx[7]; e = idx[8];
      mis = exp_mis(sz, a, d);
      ea  = mis | e;
      rq  = (sz == 2'd1 && d) ? "R1" : (sz[1] && d) ? "R2" : e ? "R4" : "R3";
      drive(m, a, sz, w, d, e);
      #1; chk(rq, "abort", 32'(abort), 32'(ea));
      @(negedge clk); idle();
      chk("R5", "valid", 32'(s_valid), 32'(ea));
      chk("R7", "overrun", 32'(s_ovr), 0);
      if (ea) chk_rec("R5", m, a, sz, w, d, mis ? 1'b0 : 1'b1);
      clr = 1'b1;
      @(negedge clk); clr = 1'b0;
      chk("R8", "valid after clear", 32'(s_valid), 0);
    end

    // no valid: ext abort ignored, nothing captured, R4
    valid = 1'b0; ext = 1'b1; addr = 32'h0000_0003; size = 2'd2; dat = 1'b1;
    #1; chk("R4", "abort idle", 32'(abort), 0);
    @(negedge clk); ext = 1'b0;
    chk("R4", "valid idle", 32'(s_valid), 0);

    // combined cause: misaligned word plus ext abort -> type 0, R6
    drive(2'd3, 32'h1234_5671, 2'd2, 1'b1, 1'b1, 1'b1);
    @(negedge clk); idle();
    chk_rec("R6", 2'd3, 32'h1234_5671, 2'd2, 1'b1, 1'b1, 1'b0);

    // held record: aligned access and second abort, R7
    drive(2'd1, 32'h0000_0100, 2'd2, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    chk("R7", "overrun quiet", 32'(s_ovr), 0);
    drive(2'd2, 32'hAAAA_0001, 2'd1, 1'b0, 1'b1, 1'b0);
    @(negedge clk); idle();
    chk("R7", "overrun set", 32'(s_ovr), 1);
    chk("R7", "valid held", 32'(s_valid), 1);
    chk_rec("R7", 2'd3, 32'h1234_5671, 2'd2, 1'b1, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    chk("R7", "overrun sticky", 32'(s_ovr), 1);

    // clear collides with abort: fresh record, R8
    clr = 1'b1;
    drive(2'd0, 32'h0000_0FFE, 2'd0, 1'b0, 1'b0, 1'b1);
    @(negedge clk); idle(); clr = 1'b0;
    chk("R8", "valid collide", 32'(s_valid), 1);
    chk("R8", "overrun collide", 32'(s_ovr), 0);
    chk_rec("R8", 2'd0, 32'h0000_0FFE, 2'd0, 1'b0, 1'b0, 1'b1);

    // overrun then plain clear, R8
    drive(2'd1, 32'h0000_0003, 2'd3, 1'b1, 1'b1, 1'b0);
    @(negedge clk); idle();
    chk("R8", "overrun before clear", 32'(s_ovr), 1);
    clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    chk("R8", "valid cleared", 32'(s_valid), 0);
    chk("R8", "overrun cleared", 32'(s_ovr), 0);

    // mid-run reset, R9
    drive(2'd2, 32'hFFFF_FFFF, 2'd1, 1'b1, 1'b1, 1'b1);
    @(negedge clk); idle();
    chk("R9", "captured before reset", 32'(s_valid), 1);
    #2 rst_n = 1'b0;
    #1 chk_zero("R9");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); chk_zero("R9");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule